// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block turns one PWM reference into two drive signals for a half-bridge: the high-side drive follows the reference and the low-side drive follows its inverse. A switch in a bridge leg needs longer to turn off than to turn on. The block therefore holds back every turn-on by a programmable dead time, so that the opposite switch has fully stopped conducting before this one starts. Turn-off edges are passed through with no delay. As a result the two drives are never both active.

The dead time is a 7-bit count of instruction cycles. One instruction cycle is four oscillator clocks, and a divide-by-four prescaler that runs freely from reset marks each one. The reference and the count are synchronous to the oscillator clock. Each turn-on latches the count at its reference edge, so a count written while a delay is running takes effect only at the next edge. If the reference flips back before the delay ends, the pending turn-on is dropped.

Top module: `hb_deadband_gen`

## Requirements
- R1: While `rst_n` is low, both `drv_hi` and `drv_lo` are low. They stay low through the two rising edges that follow its release.
- R2: `drv_hi` is active only while `pwm_ref` is 1, and `drv_lo` only while `pwm_ref` is 0. The two are never high in the same cycle.
- R3: A drive goes low right after the first rising edge at which `pwm_ref` is sampled in that drive's inactive state. No delay is added.
- R4: When the latched count is 0, a drive goes high right after the same rising edge that samples the reference in its active state.
- R5: With a latched count N from 1 to 127, a drive goes high at the N-th instruction tick that falls strictly after the edge that samples the reference change. Ticks come every four oscillator clocks. The resulting delay is 4N-3 to 4N clocks.
- R6: If the reference returns to the drive's inactive state before its pending turn-on, the drive stays low. A later change starts a fresh delay.
- R7: The count is latched at the edge that samples the reference change. A change to `dly_count` while a delay runs does not alter that delay.
- R8: Counting rising edges of `clk_osc` from the release of `rst_n`, the reference is first sampled on edge 3. Instruction ticks are counted on edges 6, 10, 14 and so on. A reference level that is active at edge 3 starts a delay at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_ref | input | 1 | PWM reference waveform, synchronous to `clk_osc` |
| dly_count | input | 7 | Dead time in instruction cycles (0 to 127) |
| drv_hi | output | 1 | High-side drive, active high |
| drv_lo | output | 1 | Low-side drive, active high |

## Verification
Two events can fall on the same clock edge. One drive turns off on a reference edge while the other begins its delay. Separately, a pending turn-on can mature on a tick in the very cycle the reference flips back. The bench provokes both by sweeping every count with the reference held long enough to complete each delay, then by pulses shorter than the delay and one-cycle glitches. Each drive is judged every cycle against an arithmetic model of the tick grid.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DLY_W   = 7;
  localparam int PRE_DIV = 4;
  localparam int N_CH    = 2;
  localparam int CH_HI   = 0;
  localparam int CH_LO   = 1;
endpackage

// File: rtl/db_rst_sync.sv
module db_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/db_prescaler.sv
module db_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick = (phase_q == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R5
endmodule

// File: rtl/db_edge_timer.sv
module db_edge_timer #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             want,
  input  logic [DLY_W-1:0] dly,
  output logic             drive
);
  logic             out_q, out_d;
  logic             pend_q, pend_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] tgt_q, tgt_d;
  logic [DLY_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    out_d  = out_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    if (!want) begin
      out_d  = 1'b0;
      pend_d = 1'b0;
    end else if (!out_q && !pend_q) begin
      if (dly == '0) begin
        out_d = 1'b1;
      end else begin
        pend_d = 1'b1;
        tgt_d  = dly;
        cnt_d  = '0;
      end
    end else if (pend_q && tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc == tgt_q) begin
        out_d  = 1'b1;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else begin
      out_q  <= out_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
    end
  end

  assign drive = out_q;

  AST_OFF_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !want |=> !drive); // R3
  AST_ZERO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (want && !drive && !pend_q && dly == '0) |=> drive); // R4
  AST_WAIT_FOR_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick) |=> !drive); // R5
  AST_CANCEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !want) |=> (!drive && !pend_q)); // R6
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && want) |=> $stable(tgt_q)); // R7
endmodule

// File: rtl/hb_deadband_gen.sv
module hb_deadband_gen #(
  parameter int DLY_W = db_pkg::DLY_W
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             pwm_ref,
  input  logic [DLY_W-1:0] dly_count,
  output logic             drv_hi,
  output logic             drv_lo
);
  localparam int NCH = db_pkg::N_CH;

  logic           rst_n_int;
  logic           tick;
  logic [NCH-1:0] want;
  logic [NCH-1:0] drive;

  db_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk_osc),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  db_prescaler #(.DIV(db_pkg::PRE_DIV)) u_pre (
    .clk   (clk_osc),
    .rst_n (rst_n_int),
    .tick  (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    if (ch == db_pkg::CH_HI) begin : g_hi
      assign want[ch] = pwm_ref;
    end else begin : g_lo
      assign want[ch] = ~pwm_ref;
    end
    db_edge_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk   (clk_osc),
      .rst_n (rst_n_int),
      .tick  (tick),
      .want  (want[ch]),
      .dly   (dly_count),
      .drive (drive[ch])
    );
  end

  assign drv_hi = drive[db_pkg::CH_HI];
  assign drv_lo = drive[db_pkg::CH_LO];

  AST_NO_OVERLAP: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(drv_hi && drv_lo)); // R2
  AST_RESET_LOW: assert property (@(posedge clk_osc)
    !rst_n_int |=> (!drv_hi && !drv_lo)); // R1
endmodule

// File: tb/sim_hb_deadband_gen.sv
`timescale 1ns/1ps
module sim_hb_deadband_gen;
  logic       clk_osc = 1'b0;
  logic       rst_n;
  logic       pwm_ref;
  logic [6:0] dly_count;
  logic       drv_hi, drv_lo;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    done = 0;
  bit    wprev [2];
  int    rise_at [2];
  bit    expv [2];

  always #2 clk_osc = ~clk_osc;

  hb_deadband_gen u0 (
    .clk_osc(clk_osc), .rst_n(rst_n), .pwm_ref(pwm_ref),
    .dly_count(dly_count), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  function automatic int rise_edge(int e, int n);
    int t;
    if (n == 0) return e;
    t = e + 1;
    while (t % 4 != 2) t++;
    return t + 4 * (n - 1);
  endfunction

  // Arithmetic model: ticks on edges 6,10,14,... ; sampling from edge 3 (R8)
  always @(posedge clk_osc) begin
    if (!rst_n) begin
      cyc = 0;
      for (int c = 0; c < 2; c++) begin wprev[c] = 0; expv[c] = 0; rise_at[c] = 0; end
    end else begin
      cyc = cyc + 1;
      for (int c = 0; c < 2; c++) begin
        bit w;
        w = (c == 0) ? pwm_ref : !pwm_ref;
        if (cyc >= 3) begin
          if (w && !wprev[c]) rise_at[c] = rise_edge(cyc, int'(dly_count));
          wprev[c] = w;
          expv[c] = w && (cyc >= rise_at[c]);
        end else begin
          expv[c] = 0;
        end
      end
    end
  end

  task automatic check1(string req, string what, bit act, bit expd);
    checks++;
    if (act !== expd) begin
      failures++;
      $display("FAIL %s %s at edge %0d actual=%0b expected=%0b", req, what, cyc, act, expd);
    end
  endtask

  always @(negedge clk_osc) begin
    if (!done) begin
      if (!rst_n) begin
        check1("R1", "drv_hi in reset", drv_hi, 1'b0);
        check1("R1", "drv_lo in reset", drv_lo, 1'b0);
      end else begin
        check1((!expv[0] && !pwm_ref && cyc >= 3) ? "R3" : cur_req, "drv_hi", drv_hi, expv[0]);
        check1((!expv[1] &&  pwm_ref && cyc >= 3) ? "R3" : cur_req, "drv_lo", drv_lo, expv[1]);
        check1("R2", "overlap", drv_hi & drv_lo, 1'b0);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_osc);
  endtask

  initial begin
    rst_n = 1'b0; pwm_ref = 1'b0; dly_count = 7'd1;
    wait_cyc(4);
    rst_n = 1'b1;
    cur_req = "R8";
    wait_cyc(12);
    // sweep every count (R4 for zero, R5 otherwise)
    for (int n = 0; n < 128; n++) begin
      cur_req = (n == 0) ? "R4" : "R5";
      dly_count = 7'(n);
      pwm_ref = 1'b1; wait_cyc(4 * n + 8);
      pwm_ref = 1'b0; wait_cyc(4 * n + 8);
    end
    // R6: pulses shorter than the dead time, including one-cycle glitches
    cur_req = "R6";
    for (int n = 2; n < 40; n += 3) begin
      dly_count = 7'(n);
      pwm_ref = 1'b1; wait_cyc(2 * n);
      pwm_ref = 1'b0; wait_cyc(1);
      pwm_ref = 1'b1; wait_cyc(1);
      pwm_ref = 1'b0; wait_cyc(4 * n + 8);
    end
    // R7: count changes while a delay is running
    cur_req = "R7";
    dly_count = 7'd20;
    pwm_ref = 1'b1; wait_cyc(5);
    dly_count = 7'd2; wait_cyc(90);
    pwm_ref = 1'b0; wait_cyc(3);
    dly_count = 7'd30; wait_cyc(20);
    pwm_ref = 1'b1; wait_cyc(2);
    dly_count = 7'd0; wait_cyc(130);
    pwm_ref = 1'b0; wait_cyc(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_osc);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule